// File: doc/BRIEF.md
# Dual-Channel Pipeline Stage-Code Combiner

This block sits behind two three-stage pipelined analog-to-digital converters. For every sample, each converter stage gives a coarse code: the first and second stages give 3 bits each and the third gives 4 bits. Each stage passes a residue, amplified by four, to the next stage. The codes of one sample arrive at different times. The block delays the early codes so that all three codes of a sample meet in one register. It then adds them with overlapping weights, so that a decision error of up to half a step in an early stage is cancelled by the later stage. The sum is clamped into the 8-bit output range.

The corrected word goes into an output latch. Each channel's latch drives its bus through a three-state buffer. Channel A is enabled by a high level and channel B by a low level. A flag beside the data marks words that came from a filled pipeline. A rate select input can halve the sample rate, so that every register stage moves only on every second clock. The analog stages are outside the block; the bench generates stage codes from a behavioural residue model.

Top module: `adc_ec_top`

## Requirements
- R1: While reset is asserted, and from the moment it is asserted, both data buses read 0 (when enabled) and the valid flag reads 0.
- R2: The first-stage code of a sample is held one advance longer than the second- and third-stage codes of the same sample, so that the three are combined together; a stream whose codes change every sample gives the correct result for every sample.
- R3: The output word equals 32·first + 8·second + third − 20, where first and second are the 3-bit codes and third is the 4-bit code, each read as an unsigned number.
- R4: A combined value below 0 is output as 0.
- R5: A combined value above 255 is output as 255.
- R6: A sample whose first-stage code is taken at advance edge k appears on the output bus right after advance edge k+3.
- R7: After reset, the outputs of the first three advance edges carry valid flag 0, and the output of every later advance carries valid flag 1.
- R8: Channel A drives its bus when its enable is 1 and leaves it undriven (high impedance) when the enable is 0.
- R9: Channel B drives its bus when its enable is 0 and leaves it undriven when the enable is 1.
- R10: With the rate select at 1, the pipeline advances only on every second clock, beginning with the second clock after the select rises; the bus does not change between advances. With the rate select at 0, it advances on every clock.
- R11: An output enable affects only the buses: the pipeline keeps converting while a bus is undriven, and the latest word appears as soon as the bus is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_rate | input | 1 | 1 = advance the pipeline on every second clock |
| a_s1 | input | 3 | Channel A first-stage code |
| a_s2 | input | 3 | Channel A second-stage code |
| a_s3 | input | 4 | Channel A third-stage code |
| b_s1 | input | 3 | Channel B first-stage code |
| b_s2 | input | 3 | Channel B second-stage code |
| b_s3 | input | 4 | Channel B third-stage code |
| oe_a | input | 1 | Channel A bus enable, active high |
| oe_b_n | input | 1 | Channel B bus enable, active low |
| a_dout | output | 8 | Channel A corrected sample, three-state |
| b_dout | output | 8 | Channel B corrected sample, three-state |
| dout_valid | output | 1 | Latched words come from a filled pipeline |

## Verification
A first-stage code held in the wrong slot shows up as a result off by a multiple of 32, on the first sample whose neighbours differ. That sample reaches the bus three advances after it enters. A wrong weight or offset inside the combiner makes every stream word wrong, and the saturation corners show it at once. A rate-phase register that drifts makes the bus change between advances, or leaves it a whole sample behind, within two clocks of the rate select rising. A fill-flag chain of the wrong length moves the rise of the valid flag by one advance.

// File: rtl/adc_ec_pkg.sv
package adc_ec_pkg;

  // Pipeline advance policy chosen by the rate select input.
  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_mode_e;

  // Clamp an integer into [0, hi].
  function automatic int clip_range(input int v, input int hi);
    if (v < 0)       return 0;
    else if (v > hi) return hi;
    else             return v;
  endfunction

endpackage

// File: rtl/ec_clock_ctrl.sv
module ec_clock_ctrl #(
  parameter int PIPE_DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  output logic rst_sync_n,
  output logic adv,
  output logic data_valid
);
  import adc_ec_pkg::*;

  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0]   sync_q;
  logic                  phase_q, phase_d;
  logic [PIPE_DEPTH-1:0] fill_q, fill_d;
  rate_mode_e            mode;

  // Reset goes low asynchronously and comes back high on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_LEN-1];

  always_comb begin
    mode    = rate_mode_e'(half_rate);
    adv     = (mode == RATE_FULL) | phase_q;
    phase_d = (mode == RATE_HALF) ? ~phase_q : 1'b0;
    fill_d  = fill_q;
    if (adv) fill_d = {fill_q[PIPE_DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= 1'b0;
      fill_q  <= '0;
    end else begin
      phase_q <= phase_d;
      fill_q  <= fill_d;
    end
  end

  assign data_valid = fill_q[PIPE_DEPTH-1];

endmodule

// File: rtl/ec_stage_align.sv
module ec_stage_align #(
  parameter int S1_W = 3,
  parameter int S2_W = 3,
  parameter int S3_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [S1_W-1:0] s1,
  input  logic [S2_W-1:0] s2,
  input  logic [S3_W-1:0] s3,
  output logic [S1_W-1:0] d1,
  output logic [S2_W-1:0] d2,
  output logic [S3_W-1:0] d3
);

  logic [S1_W-1:0] s1_q, s1_d;
  logic [S1_W-1:0] d1_q, d1_d;
  logic [S2_W-1:0] d2_q, d2_d;
  logic [S3_W-1:0] d3_q, d3_d;

  always_comb begin
    s1_d = s1_q;
    d1_d = d1_q;
    d2_d = d2_q;
    d3_d = d3_q;
    if (adv) begin
      s1_d = s1;     // first stage decides one advance early
      d1_d = s1_q;
      d2_d = s2;
      d3_d = s3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      d1_q <= '0;
      d2_q <= '0;
      d3_q <= '0;
    end else begin
      s1_q <= s1_d;
      d1_q <= d1_d;
      d2_q <= d2_d;
      d3_q <= d3_d;
    end
  end

  assign d1 = d1_q;
  assign d2 = d2_q;
  assign d3 = d3_q;

endmodule

// File: rtl/ec_combine.sv
module ec_combine #(
  parameter int S1_W    = 3,
  parameter int S2_W    = 3,
  parameter int S3_W    = 4,
  parameter int OVERLAP = 1,
  parameter int OUT_W   = 8,
  parameter int OFFSET  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [S1_W-1:0]  d1,
  input  logic [S2_W-1:0]  d2,
  input  logic [S3_W-1:0]  d3,
  output logic [OUT_W-1:0] corr
);
  import adc_ec_pkg::*;

  // Each later stage overlaps the earlier one by OVERLAP bits.
  localparam int W3   = 1;
  localparam int W2   = W3 << (S3_W - OVERLAP);
  localparam int W1   = W2 << (S2_W - OVERLAP);
  localparam int MAXV = (1 << OUT_W) - 1;

  int               raw;
  logic [OUT_W-1:0] corr_q, corr_d;

  always_comb begin
    raw    = int'(d1) * W1 + int'(d2) * W2 + int'(d3) * W3 - OFFSET;
    corr_d = corr_q;
    if (adv) corr_d = OUT_W'(clip_range(raw, MAXV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) corr_q <= '0;
    else        corr_q <= corr_d;
  end

  assign corr = corr_q;

endmodule

// File: rtl/ec_out_latch.sv
module ec_out_latch #(
  parameter int OUT_W       = 8,
  parameter bit OE_ACT_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [OUT_W-1:0] din,
  input  logic             oe,
  output logic [OUT_W-1:0] q_o,
  output logic             drive_o,
  output wire  [OUT_W-1:0] pad
);

  logic [OUT_W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (adv) q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  generate
    if (OE_ACT_HIGH) begin : g_hi
      assign drive_o = oe;
    end else begin : g_lo
      assign drive_o = ~oe;
    end
  endgenerate

  assign q_o = q_q;
  assign pad = drive_o ? q_q : {OUT_W{1'bz}};

endmodule

// File: rtl/adc_ec_top.sv
module adc_ec_top #(
  parameter int S1_W    = 3,
  parameter int S2_W    = 3,
  parameter int S3_W    = 4,
  parameter int OVERLAP = 1,
  parameter int OUT_W   = 8,
  parameter int OFFSET  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_rate,
  input  logic [S1_W-1:0]  a_s1,
  input  logic [S2_W-1:0]  a_s2,
  input  logic [S3_W-1:0]  a_s3,
  input  logic [S1_W-1:0]  b_s1,
  input  logic [S2_W-1:0]  b_s2,
  input  logic [S3_W-1:0]  b_s3,
  input  logic             oe_a,
  input  logic             oe_b_n,
  output wire  [OUT_W-1:0] a_dout,
  output wire  [OUT_W-1:0] b_dout,
  output logic             dout_valid
);

  localparam int NCH        = 2;
  localparam int PIPE_DEPTH = 4;   // first-code hold, align, combine, latch

  logic             rst_sync_n;
  logic             adv;
  logic [S1_W-1:0]  s1_in  [NCH];
  logic [S2_W-1:0]  s2_in  [NCH];
  logic [S3_W-1:0]  s3_in  [NCH];
  logic [OUT_W-1:0] corr_q [NCH];
  logic [OUT_W-1:0] lat_a_q, lat_b_q;
  logic             a_drive, b_drive;

  ec_clock_ctrl #(.PIPE_DEPTH(PIPE_DEPTH)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_rate (half_rate),
    .rst_sync_n(rst_sync_n),
    .adv       (adv),
    .data_valid(dout_valid)
  );

  assign s1_in[0] = a_s1;
  assign s2_in[0] = a_s2;
  assign s3_in[0] = a_s3;
  assign s1_in[1] = b_s1;
  assign s2_in[1] = b_s2;
  assign s3_in[1] = b_s3;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [S1_W-1:0] d1;
      logic [S2_W-1:0] d2;
      logic [S3_W-1:0] d3;

      ec_stage_align #(.S1_W(S1_W), .S2_W(S2_W), .S3_W(S3_W)) u_align (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .adv  (adv),
        .s1   (s1_in[ch]),
        .s2   (s2_in[ch]),
        .s3   (s3_in[ch]),
        .d1   (d1),
        .d2   (d2),
        .d3   (d3)
      );

      ec_combine #(
        .S1_W(S1_W), .S2_W(S2_W), .S3_W(S3_W),
        .OVERLAP(OVERLAP), .OUT_W(OUT_W), .OFFSET(OFFSET)
      ) u_comb (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .adv  (adv),
        .d1   (d1),
        .d2   (d2),
        .d3   (d3),
        .corr (corr_q[ch])
      );
    end
  endgenerate

  ec_out_latch #(.OUT_W(OUT_W), .OE_ACT_HIGH(1'b1)) u_lat_a (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv    (adv),
    .din    (corr_q[0]),
    .oe     (oe_a),
    .q_o    (lat_a_q),
    .drive_o(a_drive),
    .pad    (a_dout)
  );

  ec_out_latch #(.OUT_W(OUT_W), .OE_ACT_HIGH(1'b0)) u_lat_b (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv    (adv),
    .din    (corr_q[1]),
    .oe     (oe_b_n),
    .q_o    (lat_b_q),
    .drive_o(b_drive),
    .pad    (b_dout)
  );

endmodule

// File: rtl/ec_checks.sv
module ec_checks #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv,
  input logic             half_rate,
  input logic             dout_valid,
  input logic [OUT_W-1:0] corr_a,
  input logic [OUT_W-1:0] lat_a,
  input logic [OUT_W-1:0] lat_b,
  input logic             oe_a,
  input logic             oe_b_n,
  input logic             a_drive,
  input logic             b_drive
);

  logic [2:0] adv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        adv_cnt <= '0;
    else if (adv && adv_cnt != 3'd4)   adv_cnt <= adv_cnt + 3'd1;
  end

  // R7: the flag rises on the fourth advance after reset, never sooner
  a_r7_valid_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid == (adv_cnt == 3'd4));

  // R6: the latch takes the combiner's word on every advance
  a_r6_latch_takes_corr: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (lat_a == $past(corr_a)));

  // R10: no advance, no change on the outputs
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(lat_a) && $stable(lat_b)));

  // R10: at half rate an advance is followed by an idle clock
  a_r10_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate && adv) |=> (!adv || !half_rate));

  // R8: channel A drives on a high enable
  a_r8_a_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    a_drive == oe_a);

  // R9: channel B drives on a low enable
  a_r9_b_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    b_drive == !oe_b_n);

endmodule

bind adc_ec_top ec_checks #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .adv       (adv),
  .half_rate (half_rate),
  .dout_valid(dout_valid),
  .corr_a    (corr_q[0]),
  .lat_a     (lat_a_q),
  .lat_b     (lat_b_q),
  .oe_a      (oe_a),
  .oe_b_n    (oe_b_n),
  .a_drive   (a_drive),
  .b_drive   (b_drive)
);

// File: tb/tb_adc_ec_top.sv
module tb_adc_ec_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, half_rate, oe_a, oe_b_n;
  logic [2:0] a_s1, a_s2, b_s1, b_s2;
  logic [3:0] a_s3, b_s3;
  wire  [7:0] a_bus, b_bus;
  wire        dout_valid;

  // Undriven buses read as all ones.
  generate
    for (genvar i = 0; i < 8; i++) begin : g_pu
      pullup pu_a (a_bus[i]);
      pullup pu_b (b_bus[i]);
    end
  endgenerate

  adc_ec_top dut (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
    .a_s1(a_s1), .a_s2(a_s2), .a_s3(a_s3),
    .b_s1(b_s1), .b_s2(b_s2), .b_s3(b_s3),
    .oe_a(oe_a), .oe_b_n(oe_b_n),
    .a_dout(a_bus), .b_dout(b_bus), .dout_valid(dout_valid)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int ca1 [64], ca2 [64], ca3 [64], ea [64];
  int cb1 [64], cb2 [64], cb3 [64], eb [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_val(input int d1, input int d2, input int d3);
    int v;
    v = 32 * d1 + 8 * d2 + d3 - 20;
    if (v < 0)   v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  // Behavioural residue model: x is the ideal sample, e1/e2 are comparator errors.
  task automatic model(input int x, input int e1, input int e2,
                       output int d1, output int d2, output int d3);
    int t, r1, v, u;
    t  = x + e1;
    d1 = (t < 0) ? 0 : t / 32;
    if (d1 > 7) d1 = 7;
    r1 = x - 32 * d1;
    v  = r1 + 16;
    u  = v + e2;
    d2 = (u < 0) ? 0 : u / 8;
    if (d2 > 7) d2 = 7;
    d3 = v - 8 * d2 + 4;
  endtask

  task automatic drive_step(input int k, input int n);
    a_s1 = (k < n) ? 3'(ca1[k]) : 3'd0;
    b_s1 = (k < n) ? 3'(cb1[k]) : 3'd0;
    if (k >= 1 && k - 1 < n) begin
      a_s2 = 3'(ca2[k-1]); a_s3 = 4'(ca3[k-1]);
      b_s2 = 3'(cb2[k-1]); b_s3 = 4'(cb3[k-1]);
    end else begin
      a_s2 = '0; a_s3 = '0; b_s2 = '0; b_s3 = '0;
    end
  endtask

  // Feeds n samples; the output of advance k must be sample k-3.
  task automatic run_stream(input bit half, input int n, input bit fill_chk, input string req);
    int prev_a, prev_b;
    @(negedge clk);
    half_rate = half;
    for (int k = 0; k < n + 3; k++) begin
      drive_step(k, n);
      if (half) begin
        prev_a = a_bus; prev_b = b_bus;
        @(posedge clk); @(negedge clk);
        check(a_bus == prev_a, "R10 idle clock holds A", a_bus, prev_a);
        check(b_bus == prev_b, "R10 idle clock holds B", b_bus, prev_b);
      end
      @(posedge clk); @(negedge clk);
      if (fill_chk && k < 3)
        check(dout_valid == 1'b0, "R7 flag low while filling", dout_valid, 0);
      if (k >= 3) begin
        check(a_bus == ea[k-3], {req, " channel A"}, a_bus, ea[k-3]);
        check(b_bus == eb[k-3], {req, " channel B"}, b_bus, eb[k-3]);
        check(dout_valid == 1'b1, "R7 flag high once filled", dout_valid, 1);
      end
    end
    half_rate = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; half_rate = 1'b0; oe_a = 1'b1; oe_b_n = 1'b0;
    a_s1 = 3'd5; a_s2 = 3'd6; a_s3 = 4'd9;
    b_s1 = 3'd4; b_s2 = 3'd2; b_s3 = 4'd7;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(dout_valid == 1'b0, "R1 flag in reset", dout_valid, 0);
    check(a_bus == 8'd0, "R1 A bus in reset", a_bus, 0);
    check(b_bus == 8'd0, "R1 B bus in reset", b_bus, 0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);   // synchronous release
  endtask

  // R2 R3 R6 R7: model stream with overlap errors, full rate, from reset
  task automatic t_model_stream;
    int d1, d2, d3;
    for (int k = 0; k < 40; k++) begin
      ea[k] = (k * 37 + 11) % 256;
      model(ea[k], (k * 7) % 32 - 16, (k * 3) % 8 - 4, d1, d2, d3);
      ca1[k] = d1; ca2[k] = d2; ca3[k] = d3;
      eb[k] = (k * 53 + 200) % 256;
      model(eb[k], 15 - (k * 5) % 32, 3 - (k * 5) % 8, d1, d2, d3);
      cb1[k] = d1; cb2[k] = d2; cb3[k] = d3;
    end
    ea[0] = 0;   model(0, 15, 3, d1, d2, d3);    ca1[0] = d1; ca2[0] = d2; ca3[0] = d3;
    eb[0] = 255; model(255, -16, -4, d1, d2, d3); cb1[0] = d1; cb2[0] = d2; cb3[0] = d3;
    run_stream(1'b0, 40, 1'b1, "R2 R3 R6 corrected sample");
  endtask

  // R4 R5: out-of-range sums and the exact boundaries
  task automatic t_saturate;
    int va [8][3] = '{'{7,7,15}, '{0,0,0}, '{0,2,4}, '{0,2,5},
                      '{7,6,3}, '{7,6,4}, '{3,4,5}, '{0,1,3}};
    for (int k = 0; k < 8; k++) begin
      ca1[k] = va[k][0]; ca2[k] = va[k][1]; ca3[k] = va[k][2];
      ea[k]  = ref_val(va[k][0], va[k][1], va[k][2]);
      cb1[k] = va[7-k][0]; cb2[k] = va[7-k][1]; cb3[k] = va[7-k][2];
      eb[k]  = ref_val(va[7-k][0], va[7-k][1], va[7-k][2]);
    end
    run_stream(1'b0, 8, 1'b0, "R4 R5 saturation");
  endtask

  // R10: half rate stream
  task automatic t_half_rate;
    int d1, d2, d3;
    for (int k = 0; k < 12; k++) begin
      ea[k] = (k * 71 + 3) % 256;
      model(ea[k], (k * 11) % 32 - 16, (k * 5) % 8 - 4, d1, d2, d3);
      ca1[k] = d1; ca2[k] = d2; ca3[k] = d3;
      eb[k] = (k * 29 + 90) % 256;
      model(eb[k], (k * 13) % 32 - 16, (k * 7) % 8 - 4, d1, d2, d3);
      cb1[k] = d1; cb2[k] = d2; cb3[k] = d3;
    end
    run_stream(1'b1, 12, 1'b0, "R10 half rate sample");
  endtask

  task automatic hold_codes(input int a1, input int a2, input int a3,
                            input int b1, input int b2, input int b3);
    @(negedge clk);
    a_s1 = 3'(a1); a_s2 = 3'(a2); a_s3 = 4'(a3);
    b_s1 = 3'(b1); b_s2 = 3'(b2); b_s3 = 4'(b3);
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  // R8 R9 R11: enable polarity and conversion while undriven
  task automatic t_enables;
    hold_codes(3, 4, 5, 2, 1, 6);
    check(a_bus == 8'd113, "R3 held codes A", a_bus, 113);
    check(b_bus == 8'd58,  "R3 held codes B", b_bus, 58);
    oe_a = 1'b0; #1;
    check(a_bus == 8'hFF, "R8 A undriven on low enable", a_bus, 255);
    check(b_bus == 8'd58, "R9 B still driven", b_bus, 58);
    oe_b_n = 1'b1; #1;
    check(b_bus == 8'hFF, "R9 B undriven on high enable", b_bus, 255);
    oe_a = 1'b1; #1;
    check(a_bus == 8'd113, "R8 A driven on high enable", a_bus, 113);
    oe_a = 1'b0;
    hold_codes(1, 3, 2, 4, 0, 9);
    check(a_bus == 8'hFF, "R8 A stays undriven", a_bus, 255);
    oe_a = 1'b1; oe_b_n = 1'b0; #1;
    check(a_bus == 8'd38,  "R11 A converted while undriven", a_bus, 38);
    check(b_bus == 8'd117, "R11 B converted while undriven", b_bus, 117);
  endtask

  task automatic t_async_reset;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(a_bus == 8'd0, "R1 A clears at reset assertion", a_bus, 0);
    check(b_bus == 8'd0, "R1 B clears at reset assertion", b_bus, 0);
    check(dout_valid == 1'b0, "R1 flag clears at reset assertion", dout_valid, 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_model_stream();
    t_saturate();
    t_half_rate();
    t_enables();
    t_async_reset();
    finish_run();
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

endmodule